// File: doc/BRIEF.md
# SPI Transmit/Receive FIFO Pair with Flag Interrupts

This block sits between a register interface and an SPI shift engine. It holds one transmit FIFO, which register writes fill and the shift engine drains, and one receive FIFO, which the shift engine fills and register reads drain. Each FIFO has `DEPTH` entries (16 by default). A single configuration word sets the entry width in bytes, a receive threshold and a transmit threshold. The same word carries two self-clearing flush commands.

Occupancy of both FIFOs is reported in one status word. Each direction has its own flag register, enable mask, write-one-to-clear port and interrupt line. The full, empty and above-threshold flags follow the live FIFO state. The released flag is set by a pulse from the shift engine and holds until software clears it. Bus decoding is outside this block, so each register access arrives as its own strobe, with all writes sharing one data bus.

Top module: `spi_fifo_flags`

## Requirements
- R1: After reset both counts are 0, `tx_flags` = 0x02, `rx_flags` = 0x00, both interrupts are low, and `cfg_rdata` = 0x300 (full entry width, both thresholds 0).
- R2: Each FIFO returns entries in the order they were pushed, one entry per access. The transmit count is at `stat_word[20:16]` and the receive count at `stat_word[12:8]`. Both are updated after the clock edge of the access.
- R3: A push to a full FIFO or a pop from an empty FIFO is ignored. The count stays at 16 or 0.
- R4: Configuration bits 9:8 give the entry width as bytes minus one. An entry keeps only its low (w+1)*8 bits and its upper bits read zero. Entries already stored keep the width they were written with.
- R5: Configuration bits 3:0 hold the receive threshold and bits 7:4 the transmit threshold. `cfg_rdata` returns both thresholds and the width. Bits 11 and 12 always read zero.
- R6: A configuration write with bit 11 set empties the receive FIFO, and one with bit 12 set empties the transmit FIFO, at that clock edge. The other FIFO is left alone. A flush wins over a push in the same cycle.
- R7: Transmit flag bit 0 is set while the transmit count is 16. Transmit flag bit 1 is set while the transmit count is 0.
- R8: Receive flag bit 5 is set while the receive count is strictly greater than the receive threshold.
- R9: An `eng_released` pulse sets bit 6 in both flag registers. The bit stays set until a clear write with bit 6 = 1 reaches that direction. A set in the same cycle as a clear wins. Clear writes to level bits have no effect.
- R10: Each interrupt is the OR over bits of (flag AND enable) for its direction. The enable masks use the flag bit positions and reset to 0.
- R11: A push and a pop in the same cycle on a FIFO that is neither empty nor full leave the count unchanged and keep the entry order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wdata | input | 32 | Write data shared by all register strobes |
| cfg_wr | input | 1 | Write configuration word (width, thresholds, flush commands) |
| txd_wr | input | 1 | Push `reg_wdata` into the transmit FIFO |
| txen_wr | input | 1 | Write transmit enable mask |
| rxen_wr | input | 1 | Write receive enable mask |
| txclr_wr | input | 1 | Write-one-to-clear of transmit flags |
| rxclr_wr | input | 1 | Write-one-to-clear of receive flags |
| rxd_rd | input | 1 | Pop one entry from the receive FIFO |
| rxd_rdata | output | DATA_W | Head entry of the receive FIFO |
| cfg_rdata | output | 32 | Configuration readback |
| eng_tx_pop | input | 1 | Shift engine takes one transmit entry |
| eng_tx_data | output | DATA_W | Head entry of the transmit FIFO |
| eng_rx_push | input | 1 | Shift engine delivers one receive entry |
| eng_rx_data | input | DATA_W | Receive entry from the shift engine |
| eng_released | input | 1 | Pulse: the selected target has been released |
| stat_word | output | 32 | Occupancy: receive count at 12:8, transmit count at 20:16 |
| tx_flags | output | 8 | Transmit flags: full 0, empty 1, released 6 |
| rx_flags | output | 8 | Receive flags: above threshold 5, released 6 |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Every count, flag and interrupt is registered once. It therefore reflects an access from the first clock edge that samples the strobe. The FIFO heads are read combinationally and change at that same edge. The bench asserts each strobe for exactly one cycle, launched from a falling edge. It takes its samples at the next falling edge, half a period after the edge that should have updated the outputs, so each check sees exactly one cycle of effect. Same-cycle collisions (push with pop, push with flush, set with clear) are driven as one strobe pair in a single cycle and checked at that same falling edge.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
   localparam int unsigned FLAG_W = 8;

   // Flag bit positions shared by flags, enables and clears
   localparam int unsigned FB_FULL     = 0;
   localparam int unsigned FB_EMPTY    = 1;
   localparam int unsigned FB_ABOVE    = 5;
   localparam int unsigned FB_RELEASED = 6;

   localparam logic [FLAG_W-1:0] TX_USED  = 8'b0100_0011;
   localparam logic [FLAG_W-1:0] RX_USED  = 8'b0110_0000;
   localparam logic [FLAG_W-1:0] LATCHING = 8'b0100_0000;

   // Configuration word layout
   localparam int unsigned CF_RXTHR_LSB = 0;
   localparam int unsigned CF_TXTHR_LSB = 4;
   localparam int unsigned CF_WIDTH_LSB = 8;
   localparam int unsigned CF_RXFLUSH   = 11;
   localparam int unsigned CF_TXFLUSH   = 12;
   localparam int unsigned THR_W        = 4;

   // Status word layout
   localparam int unsigned ST_RXCNT_LSB = 8;
   localparam int unsigned ST_TXCNT_LSB = 16;
   localparam int unsigned ST_CNT_MAXW  = 5;
endpackage

// File: rtl/sfp_fifo.sv
module sfp_fifo #(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic [CNT_W-1:0]  count
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_depth_bad
      $error("sfp_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr;
   logic              push_ok, pop_ok;

   assign push_ok = push && (count != CNT_W'(DEPTH));
   assign pop_ok  = pop  && (count != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         if (push_ok && !pop_ok)      count <= count + 1'b1;
         else if (pop_ok && !push_ok) count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok && !flush) mem[wr_ptr] <= push_data;
   end

   assign head = mem[rd_ptr];
endmodule

// File: rtl/sfp_flag_bank.sv
module sfp_flag_bank #(
   parameter int unsigned     W      = 8,
   parameter logic [W-1:0]    USED   = '1,
   parameter logic [W-1:0]    LATCH  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] live,
   input  logic [W-1:0] set_pulse,
   input  logic         en_wr,
   input  logic         clr_wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] flags,
   output logic         irq
);
   logic [W-1:0] en_q;
   logic         unused_in;

   assign unused_in = ^{live, set_pulse};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (en_wr) en_q <= wdata & USED;
   end

   for (genvar i = 0; i < int'(W); i++) begin : g_bit
      if (!USED[i]) begin : g_none
         assign flags[i] = 1'b0;
      end else if (LATCH[i]) begin : g_sticky
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   q <= 1'b0;
            else if (set_pulse[i])        q <= 1'b1;
            else if (clr_wr && wdata[i])  q <= 1'b0;
         end
         assign flags[i] = q;
      end else begin : g_level
         assign flags[i] = live[i];
      end
   end

   assign irq = |(flags & en_q);
endmodule

// File: rtl/spi_fifo_flags.sv
module spi_fifo_flags
   import sfp_pkg::*;
#(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       reg_wdata,
   input  logic              cfg_wr,
   input  logic              txd_wr,
   input  logic              txen_wr,
   input  logic              rxen_wr,
   input  logic              txclr_wr,
   input  logic              rxclr_wr,
   input  logic              rxd_rd,
   output logic [DATA_W-1:0] rxd_rdata,
   output logic [31:0]       cfg_rdata,
   input  logic              eng_tx_pop,
   output logic [DATA_W-1:0] eng_tx_data,
   input  logic              eng_rx_push,
   input  logic [DATA_W-1:0] eng_rx_data,
   input  logic              eng_released,
   output logic [31:0]       stat_word,
   output logic [7:0]        tx_flags,
   output logic [7:0]        rx_flags,
   output logic              tx_irq,
   output logic              rx_irq
);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam int unsigned BYTES = DATA_W / 8;

   if (DATA_W % 8 != 0 || DATA_W < 8 || DATA_W > 32) begin : g_width_bad
      $error("spi_fifo_flags: DATA_W must be 8, 16, 24 or 32");
   end
   if (CNT_W > ST_CNT_MAXW) begin : g_cnt_bad
      $error("spi_fifo_flags: DEPTH too large for the status count field");
   end

   // Configuration state
   logic [THR_W-1:0] rx_thr_q, tx_thr_q;
   logic [1:0]       width_q;
   logic             rx_flush, tx_flush;

   assign rx_flush = cfg_wr && reg_wdata[CF_RXFLUSH];
   assign tx_flush = cfg_wr && reg_wdata[CF_TXFLUSH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_thr_q <= '0;
         tx_thr_q <= '0;
         width_q  <= 2'(BYTES - 1);
      end else if (cfg_wr) begin
         rx_thr_q <= reg_wdata[CF_RXTHR_LSB +: THR_W];
         tx_thr_q <= reg_wdata[CF_TXTHR_LSB +: THR_W];
         width_q  <= reg_wdata[CF_WIDTH_LSB +: 2];
      end
   end

   always_comb begin
      cfg_rdata = '0;
      cfg_rdata[CF_RXTHR_LSB +: THR_W] = rx_thr_q;
      cfg_rdata[CF_TXTHR_LSB +: THR_W] = tx_thr_q;
      cfg_rdata[CF_WIDTH_LSB +: 2]     = width_q;
   end

   // Entry width mask, one byte lane per generate step
   logic [DATA_W-1:0] lane_mask;
   for (genvar b = 0; b < int'(BYTES); b++) begin : g_lane
      assign lane_mask[b*8 +: 8] = {8{int'(width_q) >= b}};
   end

   logic [DATA_W-1:0] tx_in, rx_in;
   assign tx_in = reg_wdata[DATA_W-1:0] & lane_mask;
   assign rx_in = eng_rx_data & lane_mask;

   // FIFOs
   logic [CNT_W-1:0] tx_cnt, rx_cnt;

   sfp_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_txq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (tx_flush),
      .push      (txd_wr),
      .push_data (tx_in),
      .pop       (eng_tx_pop),
      .head      (eng_tx_data),
      .count     (tx_cnt)
   );

   sfp_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (rx_flush),
      .push      (eng_rx_push),
      .push_data (rx_in),
      .pop       (rxd_rd),
      .head      (rxd_rdata),
      .count     (rx_cnt)
   );

   always_comb begin
      stat_word = '0;
      stat_word[ST_RXCNT_LSB +: CNT_W] = rx_cnt;
      stat_word[ST_TXCNT_LSB +: CNT_W] = tx_cnt;
   end

   // Flag sources
   logic [FLAG_W-1:0] tx_live, rx_live, rel_set;

   always_comb begin
      tx_live = '0;
      tx_live[FB_FULL]  = (tx_cnt == CNT_W'(DEPTH));
      tx_live[FB_EMPTY] = (tx_cnt == '0);
      rx_live = '0;
      rx_live[FB_ABOVE] = int'(rx_cnt) > int'(rx_thr_q);
      rel_set = '0;
      rel_set[FB_RELEASED] = eng_released;
   end

   sfp_flag_bank #(.W(FLAG_W), .USED(TX_USED), .LATCH(LATCHING)) u_txflg (
      .clk       (clk),
      .rst_n     (rst_n),
      .live      (tx_live),
      .set_pulse (rel_set),
      .en_wr     (txen_wr),
      .clr_wr    (txclr_wr),
      .wdata     (reg_wdata[FLAG_W-1:0]),
      .flags     (tx_flags),
      .irq       (tx_irq)
   );

   sfp_flag_bank #(.W(FLAG_W), .USED(RX_USED), .LATCH(LATCHING)) u_rxflg (
      .clk       (clk),
      .rst_n     (rst_n),
      .live      (rx_live),
      .set_pulse (rel_set),
      .en_wr     (rxen_wr),
      .clr_wr    (rxclr_wr),
      .wdata     (reg_wdata[FLAG_W-1:0]),
      .flags     (rx_flags),
      .irq       (rx_irq)
   );

   logic unused_bits;
   assign unused_bits = ^{reg_wdata};
endmodule

// File: rtl/spi_fifo_flags_chk.sv
module spi_fifo_flags_chk #(
   parameter int unsigned DEPTH = 16
) (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] reg_wdata,
   input logic        cfg_wr,
   input logic        txd_wr,
   input logic        eng_tx_pop,
   input logic        eng_released,
   input logic [31:0] stat_word,
   input logic [7:0]  tx_flags,
   input logic [7:0]  rx_flags,
   input logic        tx_irq,
   input logic        rx_irq
);
   logic [4:0] tx_c, rx_c;
   assign tx_c = stat_word[20:16];
   assign rx_c = stat_word[12:8];

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(tx_c) <= int'(DEPTH)) && (int'(rx_c) <= int'(DEPTH)));

   // R3
   full_push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(tx_c) == int'(DEPTH) && txd_wr && !eng_tx_pop && !(cfg_wr && reg_wdata[12]))
      |=> int'(tx_c) == int'(DEPTH));

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr && reg_wdata[12])
      |=> (tx_c == $past(tx_c)) || (tx_c == $past(tx_c) + 5'd1) || (tx_c + 5'd1 == $past(tx_c)));

   // R6
   rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && reg_wdata[11]) |=> rx_c == 5'd0);

   // R7
   full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_flags[0] && tx_flags[1]));

   // R9
   released_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_released |=> tx_flags[6] && rx_flags[6]);

   // R10
   quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((tx_flags == 8'h00) |-> !tx_irq) and ((rx_flags == 8'h00) |-> !rx_irq));
endmodule

bind spi_fifo_flags spi_fifo_flags_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/spi_fifo_flags_test.sv
module spi_fifo_flags_test;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [31:0]   reg_wdata;
   logic          cfg_wr, txd_wr, txen_wr, rxen_wr, txclr_wr, rxclr_wr, rxd_rd;
   logic [DW-1:0] rxd_rdata, eng_tx_data, eng_rx_data;
   logic [31:0]   cfg_rdata, stat_word;
   logic          eng_tx_pop, eng_rx_push, eng_released;
   logic [7:0]    tx_flags, rx_flags;
   logic          tx_irq, rx_irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   spi_fifo_flags #(.DEPTH(16), .DATA_W(DW)) uut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic quiet;
      cfg_wr = 0; txd_wr = 0; txen_wr = 0; rxen_wr = 0; txclr_wr = 0; rxclr_wr = 0;
      rxd_rd = 0; eng_tx_pop = 0; eng_rx_push = 0; eng_released = 0;
   endtask

   task automatic cfg(input logic [31:0] d);
      reg_wdata = d; cfg_wr = 1; @(negedge clk); quiet;
   endtask
   task automatic txpush(input logic [31:0] d);
      reg_wdata = d; txd_wr = 1; @(negedge clk); quiet;
   endtask
   task automatic txpop;
      eng_tx_pop = 1; @(negedge clk); quiet;
   endtask
   task automatic rxpush(input logic [31:0] d);
      eng_rx_data = d; eng_rx_push = 1; @(negedge clk); quiet;
   endtask
   task automatic rxpop;
      rxd_rd = 1; @(negedge clk); quiet;
   endtask
   task automatic flagwr(input int which, input logic [7:0] d);
      reg_wdata = {24'h0, d};
      case (which)
         0: txen_wr = 1;
         1: rxen_wr = 1;
         2: txclr_wr = 1;
         default: rxclr_wr = 1;
      endcase
      @(negedge clk); quiet;
   endtask
   task automatic release_pulse;
      eng_released = 1; @(negedge clk); quiet;
   endtask

   task automatic t_reset;
      chk("R1 stat", stat_word, 32'h0);
      chk("R1 txflags", {24'h0, tx_flags}, 32'h02);
      chk("R1 rxflags", {24'h0, rx_flags}, 32'h00);
      chk("R1 irqs", {30'h0, tx_irq, rx_irq}, 32'h0);
      chk("R1 cfg", cfg_rdata, 32'h300);
   endtask

   task automatic t_order;
      cfg(32'h300);
      txpush(32'hA1); txpush(32'hA2); txpush(32'hA3);
      chk("R2 tx count", stat_word, 32'h0003_0000);
      chk("R2 tx head 1", eng_tx_data, 32'hA1);
      txpop;
      chk("R2 tx head 2", eng_tx_data, 32'hA2);
      chk("R2 tx count after pop", stat_word, 32'h0002_0000);
      rxpush(32'hB1); rxpush(32'hB2);
      chk("R2 rx count", stat_word[12:8], 32'd2);
      chk("R2 rx head 1", rxd_rdata, 32'hB1);
      rxpop;
      chk("R2 rx head 2", rxd_rdata, 32'hB2);
      txpop; txpop; rxpop;
      chk("R2 drained", stat_word, 32'h0);
   endtask

   task automatic t_simul;
      txpush(32'hC1); txpush(32'hC2);
      reg_wdata = 32'hC3; txd_wr = 1; eng_tx_pop = 1; @(negedge clk); quiet;
      chk("R11 tx count", stat_word[20:16], 32'd2);
      chk("R11 tx head", eng_tx_data, 32'hC2);
      txpop;
      chk("R11 tx next", eng_tx_data, 32'hC3);
      rxpush(32'hD1);
      eng_rx_data = 32'hD2; eng_rx_push = 1; rxd_rd = 1; @(negedge clk); quiet;
      chk("R11 rx count", stat_word[12:8], 32'd1);
      chk("R11 rx head", rxd_rdata, 32'hD2);
      cfg(32'h1B00);
      chk("R6 both flushed", stat_word, 32'h0);
   endtask

   task automatic t_full;
      for (int i = 0; i < 16; i++) txpush(32'h100 + i);
      chk("R2 tx count 16", stat_word[20:16], 32'd16);
      chk("R7 full flag", {24'h0, tx_flags}, 32'h01);
      txpush(32'hDEAD);
      chk("R3 push on full", stat_word[20:16], 32'd16);
      for (int i = 0; i < 16; i++) begin
         chk("R3 order after overflow", eng_tx_data, 32'h100 + i);
         txpop;
      end
      txpop;
      chk("R3 pop on empty", stat_word, 32'h0);
      chk("R7 empty flag", {24'h0, tx_flags}, 32'h02);
      for (int i = 0; i < 17; i++) rxpush(32'h200 + i);
      chk("R3 rx push on full", stat_word[12:8], 32'd16);
      cfg(32'h0B00);
      rxpop;
      chk("R3 rx pop on empty", stat_word, 32'h0);
   endtask

   task automatic t_width;
      cfg(32'h000); rxpush(32'hAABBCCDD);
      cfg(32'h100); rxpush(32'hAABBCCDD);
      cfg(32'h200); rxpush(32'hAABBCCDD);
      chk("R4 width 1 byte", rxd_rdata, 32'h0000_00DD);
      rxpop;
      chk("R4 width 2 bytes", rxd_rdata, 32'h0000_CCDD);
      rxpop;
      chk("R4 width 3 bytes", rxd_rdata, 32'h00BB_CCDD);
      rxpop;
      cfg(32'h100); txpush(32'h11223344);
      chk("R4 tx width 2 bytes", eng_tx_data, 32'h0000_3344);
      cfg(32'h1300);
      txpush(32'h11223344);
      chk("R4 tx full width", eng_tx_data, 32'h1122_3344);
      cfg(32'h1300);
   endtask

   task automatic t_cfg;
      cfg(32'h395);
      chk("R5 readback", cfg_rdata, 32'h395);
      cfg(32'h18A6);
      chk("R5 flush bits read zero", cfg_rdata, 32'h0A6);
      cfg(32'h300);
   endtask

   task automatic t_rxthr;
      cfg(32'h302);
      rxpush(32'h1); rxpush(32'h2);
      chk("R8 at threshold", {24'h0, rx_flags}, 32'h00);
      rxpush(32'h3);
      chk("R8 above threshold", {24'h0, rx_flags}, 32'h20);
      chk("R10 masked irq", {31'h0, rx_irq}, 32'h0);
      flagwr(1, 8'h20);
      chk("R10 rx irq on", {31'h0, rx_irq}, 32'h1);
      rxpop;
      chk("R8 back to threshold", {24'h0, rx_flags}, 32'h00);
      chk("R10 rx irq off", {31'h0, rx_irq}, 32'h0);
      flagwr(1, 8'h00);
      cfg(32'h0B00);
   endtask

   task automatic t_flush;
      for (int i = 0; i < 4; i++) txpush(32'h40 + i);
      for (int i = 0; i < 3; i++) rxpush(32'h50 + i);
      cfg(32'h0B00);
      chk("R6 rx flush only", stat_word, 32'h0004_0000);
      reg_wdata = 32'h1300; cfg_wr = 1; txd_wr = 1; @(negedge clk); quiet;
      chk("R6 flush beats push", stat_word, 32'h0);
   endtask

   task automatic t_rel;
      release_pulse;
      chk("R9 tx released", {24'h0, tx_flags}, 32'h42);
      chk("R9 rx released", {24'h0, rx_flags}, 32'h40);
      flagwr(3, 8'h20);
      chk("R9 level clear no effect", {24'h0, rx_flags}, 32'h40);
      flagwr(0, 8'h40);
      chk("R10 tx irq released", {31'h0, tx_irq}, 32'h1);
      flagwr(3, 8'h40);
      chk("R9 rx cleared", {24'h0, rx_flags}, 32'h00);
      chk("R9 tx untouched", {24'h0, tx_flags}, 32'h42);
      reg_wdata = 32'h40; txclr_wr = 1; eng_released = 1; @(negedge clk); quiet;
      chk("R9 set beats clear", {24'h0, tx_flags}, 32'h42);
      flagwr(2, 8'h40);
      chk("R9 tx cleared", {24'h0, tx_flags}, 32'h02);
      chk("R10 tx irq off", {31'h0, tx_irq}, 32'h0);
      flagwr(0, 8'h02);
      chk("R10 tx irq empty", {31'h0, tx_irq}, 32'h1);
      flagwr(0, 8'h00);
      chk("R10 tx irq masked", {31'h0, tx_irq}, 32'h0);
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   initial begin
      quiet;
      reg_wdata = '0; eng_rx_data = '0;
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset;
      t_order;
      t_simul;
      t_full;
      t_width;
      t_cfg;
      t_rxthr;
      t_flush;
      t_rel;
      done = 1;
      summary;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         summary;
         $finish;
      end
   end
endmodule